// File: doc/BRIEF.md
# Idle-Timeout Sleep and Wake Sequencer for an H-Bridge

This block sits between the two direction inputs of a brushed-motor H-bridge and its four switch enables. It decides when the bridge may switch and when it must rest. There is no separate enable pin. The block puts itself to sleep when both direction inputs have been low without a break for an idle interval. It wakes again when at least one input has been high long enough to count as a real request. After that it waits a fixed start-up time before it lets the bridge drive.

While the block is ready, the two inputs are decoded into high-side and low-side switch enables for the two half-bridges: coast, forward, reverse or brake. In every other state all four enables are off, so both outputs float. All intervals are given in microseconds and converted to clock cycles from a clock-frequency parameter.

The state machine has five states:
- `ST_BOOT`: the single state after reset.
- `ST_READY`: the bridge is active.
- `ST_SLEEP`: the block rests.
- `ST_QUAL`: a wake request is being qualified.
- `ST_START`: the start-up delay is running.

It has these transitions:
- BOOT→SLEEP: reset ends with both inputs low.
- BOOT→READY: reset ends with an input high.
- READY→SLEEP: the idle timeout expires.
- SLEEP→QUAL: the first high sample arrives.
- QUAL→SLEEP: a low sample arrives during qualification, so the request is abandoned.
- QUAL→START: the request has qualified.
- START→READY: the start-up delay has elapsed.

Top module: `idle_sleep_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sleep_o` and `ready_o` are 0 and all four switch enables are 0, whatever the inputs.
- R2: If both inputs are low at the first clock edge after reset release, `sleep_o` is 1 after that edge, with no idle timeout.
- R3: If at least one input is high at the first clock edge after reset release, `ready_o` is 1 after that edge, with no start-up delay.
- R4: In the ready state, after SLEEP_CYC consecutive clock edges that sample both inputs low, `sleep_o` becomes 1 and `ready_o` becomes 0 at the last of those edges, and not one edge earlier.
- R5: In the ready state, any edge that samples an input high restarts the idle count, and the block stays ready.
- R6: While `sleep_o` is 1, all four enables are 0 for every input pattern.
- R7: From sleep, QUAL_CYC consecutive edges that each sample at least one input high make `sleep_o` fall at the last of them. `sleep_o` stays 1 during the qualification.
- R8: An edge that samples both inputs low during qualification returns the block to sleep. The next wake needs a fresh run of QUAL_CYC high samples.
- R9: The start-up phase lasts exactly START_CYC edges. During it, `sleep_o`, `ready_o` and all enables are 0, and input changes neither shorten nor restart it.
- R10: When ready, with (ctl_a, ctl_b) the enables are:
  - 00: all four enables off (coast).
  - 10: `hs_on[0]` and `ls_on[1]` on (forward).
  - 01: `hs_on[1]` and `ls_on[0]` on (reverse).
  - 11: `ls_on[1:0]` both on, high sides off (brake).
  - Bit 0 is the half-bridge driven by `ctl_a`.
- R11: The high-side and low-side enables of one half-bridge are never on together, and `sleep_o` and `ready_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_a | input | 1 | Direction input for half-bridge 0 |
| ctl_b | input | 1 | Direction input for half-bridge 1 |
| sleep_o | output | 1 | Block is resting (includes wake qualification) |
| ready_o | output | 1 | Bridge is operational |
| hs_on | output | 2 | High-side switch enables, bit 0 = half-bridge 0 |
| ls_on | output | 2 | Low-side switch enables, bit 0 = half-bridge 0 |

## Verification
The bench measures the exact edge on which the idle timeout fires. A counter that is off by one would fall asleep one edge early or one edge late. It also inserts a single high sample late in the timeout, which a design that failed to clear the count would ignore before sleeping early. A wake pulse one sample too short must leave the block asleep, and a second wake must then need the full run again, because a design that kept a partial count would wake early. Inputs are toggled throughout the start-up delay, which a design that restarted or skipped the delay would turn into a wrong `ready_o` edge. Both reset exits are covered, low inputs leading straight to sleep and high inputs leading straight to ready.

// File: rtl/iss_pkg.sv
package iss_pkg;

    typedef enum logic [2:0] {
        ST_BOOT  = 3'd0,
        ST_READY = 3'd1,
        ST_SLEEP = 3'd2,
        ST_QUAL  = 3'd3,
        ST_START = 3'd4
    } iss_state_e;

    // microseconds to clock cycles for a clock given in Hz
    function automatic int us_to_cycles(input int clk_hz, input int usec);
        return (clk_hz / 1_000_000) * usec;
    endfunction

endpackage

// File: rtl/iss_timer.sv
module iss_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    // the owner compares against a limit below full scale, so it never wraps
    assert_timer_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (count != '1));

endmodule

// File: rtl/iss_bridge_gate.sv
module iss_bridge_gate (
    input  logic       enable,
    input  logic [1:0] dir_in,
    output logic [1:0] hs_on,
    output logic [1:0] ls_on
);

    // each half goes high when its own input is the only one high,
    // and goes low whenever the opposite input is high
    for (genvar h = 0; h < 2; h++) begin : g_half
        always_comb begin
            hs_on[h] = enable & dir_in[h] & ~dir_in[1-h];
            ls_on[h] = enable & dir_in[1-h];
        end
    end

endmodule

// File: rtl/iss_fsm.sv
module iss_fsm
    import iss_pkg::*;
#(
    parameter int SLEEP_CYC = 50_000,
    parameter int QUAL_CYC  = 250,
    parameter int START_CYC = 2_500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_high,
    output logic sleep_o,
    output logic ready_o,
    output logic bridge_en
);

    localparam int MAX_CYC = (SLEEP_CYC > START_CYC) ?
                             ((SLEEP_CYC > QUAL_CYC) ? SLEEP_CYC : QUAL_CYC) :
                             ((START_CYC > QUAL_CYC) ? START_CYC : QUAL_CYC);
    localparam int CW = $clog2(MAX_CYC + 1) + 1;
    localparam logic [CW-1:0] SLEEP_LAST = CW'(SLEEP_CYC - 1);
    localparam logic [CW-1:0] QUAL_LAST  = CW'(QUAL_CYC - 2);
    localparam logic [CW-1:0] START_LAST = CW'(START_CYC - 1);

    iss_state_e    state, nxt;
    logic          tmr_clr, tmr_inc;
    logic [CW-1:0] count;

    iss_timer #(.W(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .count (count)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BOOT;
        end else begin
            state <= nxt;
        end
    end

    // transitions and timer control
    always_comb begin
        nxt     = state;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        unique case (state)
            ST_BOOT: begin
                tmr_clr = 1'b1;
                nxt     = any_high ? ST_READY : ST_SLEEP;
            end
            ST_READY: begin
                if (any_high) begin
                    tmr_clr = 1'b1;
                end else if (count == SLEEP_LAST) begin
                    tmr_clr = 1'b1;
                    nxt     = ST_SLEEP;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_SLEEP: begin
                tmr_clr = 1'b1;
                if (any_high) nxt = ST_QUAL;
            end
            ST_QUAL: begin
                if (!any_high) begin
                    tmr_clr = 1'b1;
                    nxt     = ST_SLEEP;
                end else if (count == QUAL_LAST) begin
                    tmr_clr = 1'b1;
                    nxt     = ST_START;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_START: begin
                if (count == START_LAST) begin
                    tmr_clr = 1'b1;
                    nxt     = ST_READY;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            default: begin
                tmr_clr = 1'b1;
                nxt     = ST_BOOT;
            end
        endcase
    end

    // outputs from state
    always_comb begin
        sleep_o   = 1'b0;
        ready_o   = 1'b0;
        bridge_en = 1'b0;
        unique case (state)
            ST_SLEEP, ST_QUAL: sleep_o = 1'b1;
            ST_READY: begin
                ready_o   = 1'b1;
                bridge_en = 1'b1;
            end
            default: ;
        endcase
    end

    assert_boot_low_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT && !any_high) |=> sleep_o);

    assert_boot_high_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT && any_high) |=> ready_o);

    assert_idle_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && any_high) |=> (ready_o && count == '0));

    assert_qual_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUAL && !any_high) |=> (state == ST_SLEEP));

    assert_start_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && count != START_LAST) |=> (state == ST_START));

endmodule

// File: rtl/idle_sleep_sequencer.sv
module idle_sleep_sequencer
    import iss_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int SLEEP_US = 1000,
    parameter int QUAL_US  = 5,
    parameter int START_US = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_a,
    input  logic       ctl_b,
    output logic       sleep_o,
    output logic       ready_o,
    output logic [1:0] hs_on,
    output logic [1:0] ls_on
);

    localparam int SLEEP_CYC = us_to_cycles(CLK_HZ, SLEEP_US);
    localparam int QUAL_CYC  = us_to_cycles(CLK_HZ, QUAL_US);
    localparam int START_CYC = us_to_cycles(CLK_HZ, START_US);

    logic [1:0] dir_in;
    logic       bridge_en;

    assign dir_in = {ctl_b, ctl_a};

    iss_fsm #(
        .SLEEP_CYC (SLEEP_CYC),
        .QUAL_CYC  (QUAL_CYC),
        .START_CYC (START_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_high  (|dir_in),
        .sleep_o   (sleep_o),
        .ready_o   (ready_o),
        .bridge_en (bridge_en)
    );

    iss_bridge_gate u_gate (
        .enable (bridge_en),
        .dir_in (dir_in),
        .hs_on  (hs_on),
        .ls_on  (ls_on)
    );

    assert_sleep_bridge_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> (hs_on == 2'b00 && ls_on == 2'b00));

    assert_no_shoot_through_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on & ls_on) == 2'b00);

    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sleep_o && ready_o));

    assert_wake_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> !ready_o);

endmodule

// File: tb/idle_sleep_sequencer_tb_top.sv
`timescale 1ns/1ps
module idle_sleep_sequencer_tb_top;

    localparam int SLP_N = 1000;
    localparam int QLF_N = 5;
    localparam int STU_N = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ca = 1'b0, cb = 1'b0;
    logic       sleep_o, ready_o;
    logic [1:0] hs_on, ls_on;

    int n_chk = 0;
    int n_bad = 0;
    bit compare_on = 1'b0;

    always #2.5 clk = ~clk;

    idle_sleep_sequencer #(
        .CLK_HZ(1_000_000), .SLEEP_US(SLP_N), .QUAL_US(QLF_N), .START_US(STU_N)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_a(ca), .ctl_b(cb),
        .sleep_o(sleep_o), .ready_o(ready_o), .hs_on(hs_on), .ls_on(ls_on)
    );

    // reference model: 0 boot, 1 ready, 2 asleep, 3 qualifying, 4 starting
    int mode = 0;
    int low_run = 0, high_run = 0, start_left = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode = 0;
        end else begin
            case (mode)
                0: begin
                    low_run = 0;
                    mode = (ca || cb) ? 1 : 2;
                end
                1: begin
                    low_run = (ca || cb) ? 0 : low_run + 1;
                    if (low_run == SLP_N) mode = 2;
                end
                2: if (ca || cb) begin
                    high_run = 1;
                    mode = 3;
                end
                3: begin
                    if (!(ca || cb)) mode = 2;
                    else begin
                        high_run++;
                        if (high_run == QLF_N) begin
                            start_left = STU_N;
                            mode = 4;
                        end
                    end
                end
                default: begin
                    start_left--;
                    if (start_left == 0) begin
                        low_run = 0;
                        mode = 1;
                    end
                end
            endcase
        end
    end

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got {sleep,ready,hs,ls}=%b expected %b", req, $time, act, exp);
        end
    endtask

    function automatic logic [5:0] model_out();
        logic [1:0] h, l;
        h = 2'b00; l = 2'b00;
        if (mode == 1) begin
            unique case ({ca, cb})
                2'b10: begin h = 2'b01; l = 2'b10; end
                2'b01: begin h = 2'b10; l = 2'b01; end
                2'b11: begin h = 2'b00; l = 2'b11; end
                default: ;
            endcase
        end
        return {(mode == 2 || mode == 3), (mode == 1), h, l};
    endfunction

    function automatic string mode_req();
        case (mode)
            0: return "R1";
            1: return "R10";
            2: return "R6";
            3: return "R7";
            default: return "R9";
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (compare_on) chk(mode_req(), {sleep_o, ready_o, hs_on, ls_on}, model_out());
    end

    task automatic set_in(input logic a, input logic b);
        @(posedge clk);
        #1;
        ca = a;
        cb = b;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [5:0] outs();
        return {sleep_o, ready_o, hs_on, ls_on};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state with inputs low and with a direction applied
        edges(3);
        chk("R1", outs(), 6'b00_0000);
        ca = 1'b1;
        #0.1;
        chk("R1", outs(), 6'b00_0000);
        ca = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", outs(), 6'b00_0000);
        compare_on = 1'b1;
        edges(1);
        chk("R2", outs(), 6'b10_0000);

        // R6: asleep, inputs high give no drive; a short request is abandoned
        set_in(1, 1);
        @(negedge clk);
        chk("R6", outs(), 6'b10_0000);
        edges(2);
        set_in(0, 0);
        edges(3);
        chk("R8", outs(), 6'b10_0000);

        // R8: after the abort a full run of high samples is needed again
        set_in(1, 0);
        edges(4);
        chk("R8", outs(), 6'b10_0000);
        edges(1);
        chk("R7", outs(), 6'b00_0000);

        // R9: inputs moving during start-up do not restart it
        set_in(0, 0);
        set_in(1, 1);
        set_in(0, 1);
        edges(46);
        chk("R9", outs(), 6'b00_0000);
        edges(1);
        chk("R9", outs(), 6'b01_1001);

        // R10: all four direction patterns while ready
        set_in(1, 0); @(negedge clk); chk("R10", outs(), 6'b01_0110);
        set_in(1, 1); @(negedge clk); chk("R10", outs(), 6'b01_0011);
        set_in(0, 1); @(negedge clk); chk("R10", outs(), 6'b01_1001);

        // R5: a single high sample late in the timeout restarts the count
        set_in(0, 0);
        @(negedge clk); chk("R10", outs(), 6'b01_0000);
        edges(599);
        set_in(0, 1);
        set_in(0, 0);
        edges(998);
        chk("R5", outs(), 6'b01_0000);

        // R4: sleep exactly at the last idle sample
        edges(1);
        chk("R4", outs(), 6'b01_0000);
        edges(1);
        chk("R4", outs(), 6'b10_0000);

        // R3: reset released with an input high goes straight to ready
        compare_on = 1'b0;
        @(posedge clk); #1 rst_n = 1'b0; ca = 1'b1; cb = 1'b0;
        edges(2);
        chk("R1", outs(), 6'b00_0000);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", outs(), 6'b00_0000);
        compare_on = 1'b1;
        edges(1);
        chk("R3", outs(), 6'b01_0110);
        edges(5);

        compare_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule